// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parked Grant

This block decides which of N initiators may use a single shared target path. Each initiator raises its bit of a request vector; the arbiter drives a registered one-hot grant vector and a busy flag that marks a transaction in progress. The owner ends its transaction with a one-cycle done pulse.

Selection is made by one comparator. Each port gets a 3-bit priority built from three terms: whether the port is requesting, whether it is the last winner and is now idle, and whether its index lies above the last winner. The largest value wins, and the lower index wins a tie. These three terms together give round-robin fairness. They also keep the grant parked on the most recent winner while nobody requests. A parked initiator that requests starts its transaction without first moving the grant, so it saves one cycle over any other port.

When the bus is idle and the selected port already holds the grant and is requesting, the transaction starts. Busy rises on the next edge and the last-winner pointer takes that port. Otherwise the grant moves to the selected port, and the start is decided again on the next cycle.

Top module: `rr_park_arb`

## Requirements
- R1: After reset, the grant is on port 0 (grant_o = 1 on bit 0 only), busy_o is 0, and the last-winner pointer is port 0.
- R2: From reset onward, exactly one bit of gnt_o is 1 in every cycle.
- R3: In an idle cycle, the priority of port i is a 3-bit value. Bit 2 is req_i[i]. Bit 1 is 1 when i is the last winner and req_i[i] is 0. Bit 0 is 1 when i is greater than the last winner. If the port with the largest value does not hold the grant, gnt_o moves to that port on the next cycle and busy_o stays 0.
- R4: If several ports share the largest priority, the lowest-numbered one among them is selected.
- R5: While busy_o is 1, gnt_o does not change. A done_i pulse while busy clears busy_o on the next cycle, and the grant stays on the same port.
- R6: In an idle cycle with no request, the grant moves to the last winner, or stays there if it is already there.
- R7: In an idle cycle where the selected port both requests and already holds the grant, busy_o goes to 1 on the next cycle, the grant does not move, and that port becomes the last winner. A parked port that requests alone therefore starts one cycle earlier than any other port.
- R8: A request that drops before its port starts a transaction leaves no trace. The last winner is unchanged, and with no other request the grant goes back to it.
- R9: done_i has no effect while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PORTS | Request per initiator |
| done_i | input | 1 | One-cycle end-of-transaction pulse from the owner |
| gnt_o | output | N_PORTS | Registered one-hot grant |
| busy_o | output | 1 | Transaction in progress |

## Verification
Two things can happen in the same cycle: a done pulse that ends a transaction, and requests from other ports that rise or fall at that moment. Separately, a parked port can request in the same idle cycle that other ports start requesting. The bench provokes both of these with random request vectors and random done pulses, and adds directed sequences for ties, for dropped requests and for the parked start. Each cycle's grant and busy values are compared with a model built from the priority rules. That model holds the last winner as a separate pointer, so a fairness error shows up as a grant on the wrong port.

// File: rtl/rr_park_pkg.sv
package rr_park_pkg;
  typedef logic [2:0] prio_t;
  localparam int unsigned PRIO_REQ  = 2;
  localparam int unsigned PRIO_PARK = 1;
  localparam int unsigned PRIO_RR   = 0;
endpackage

// File: rtl/rr_park_prio.sv
module rr_park_prio
  import rr_park_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]          req_i,
  input  logic [IW-1:0]         last_i,
  output prio_t [N-1:0]         prio_o
);
  for (genvar i = 0; i < N; i++) begin : g_port
    always_comb begin
      prio_o[i]            = '0;
      prio_o[i][PRIO_REQ]  = req_i[i];
      prio_o[i][PRIO_PARK] = (IW'(i) == last_i) && !req_i[i];
      prio_o[i][PRIO_RR]   = IW'(i) > last_i;
    end
  end
endmodule

// File: rtl/rr_park_pick.sv
module rr_park_pick
  import rr_park_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  prio_t [N-1:0]  prio_i,
  output logic [IW-1:0]  win_o
);
  prio_t best;
  // strict compare: lower index keeps a tie
  always_comb begin
    best  = prio_i[0];
    win_o = '0;
    for (int i = 1; i < N; i++) begin
      if (prio_i[i] > best) begin
        best  = prio_i[i];
        win_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rr_park_ctrl.sv
module rr_park_ctrl #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          done_i,
  input  logic [IW-1:0] win_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] last_o,
  output logic          busy_o
);
  localparam logic [N-1:0] PORT0 = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  gnt_q;
  logic [IW-1:0] last_q;
  logic          busy_q;
  logic          start;

  // selected port already parked here and asking: no grant move needed
  assign start = !busy_q && req_i[win_i] && gnt_q[win_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= PORT0;
      last_q <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (done_i) busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      last_q <= win_i;
    end else begin
      gnt_q <= PORT0 << win_i;
    end
  end

  assign gnt_o  = gnt_q;
  assign last_o = last_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/rr_park_arb.sv
module rr_park_arb
  import rr_park_pkg::*;
#(
  parameter int unsigned N_PORTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  input  logic               done_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic               busy_o
);
  localparam int unsigned IDX_W = (N_PORTS > 2) ? $clog2(N_PORTS) : 1;

  prio_t [N_PORTS-1:0] prio;
  logic  [IDX_W-1:0]   win;
  logic  [IDX_W-1:0]   last_q;

  rr_park_prio #(.N(N_PORTS), .IW(IDX_W)) u_prio (
    .req_i  (req_i),
    .last_i (last_q),
    .prio_o (prio)
  );

  rr_park_pick #(.N(N_PORTS), .IW(IDX_W)) u_pick (
    .prio_i (prio),
    .win_o  (win)
  );

  rr_park_ctrl #(.N(N_PORTS), .IW(IDX_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .done_i (done_i),
    .win_i  (win),
    .gnt_o  (gnt_o),
    .last_o (last_q),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/rr_park_arb_chk.sv
module rr_park_arb_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic          done_i,
  input logic [N-1:0]  gnt_o,
  input logic          busy_o,
  input logic [IW-1:0] last_i
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_o) == 1);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o && $stable(gnt_o));

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && done_i |=> !busy_o && $stable(gnt_o));

  p_park_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && (req_i == '0) |=> gnt_o == (ONE << $past(last_i)));

  p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(|(gnt_o & req_i)) && $stable(gnt_o));

  p_owner_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> gnt_o == (ONE << last_i));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && done_i && (req_i == '0) |=> !busy_o);
endmodule

bind rr_park_arb rr_park_arb_chk #(.N(N_PORTS), .IW(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .done_i (done_i),
  .gnt_o  (gnt_o),
  .busy_o (busy_o),
  .last_i (last_q)
);

// File: tb/rr_park_arb_test.sv
module rr_park_arb_test;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic [N-1:0] gnt;
  logic         busy;

  int n_chk = 0, n_bad = 0;
  int m_gnt = 0, m_last = 0;
  bit m_busy = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rr_park_arb #(.N_PORTS(N)) uut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .done_i (done),
    .gnt_o (gnt), .busy_o (busy)
  );

  function automatic int pick(input logic [N-1:0] r, input int last);
    int best = -1, w = 0;
    for (int i = 0; i < N; i++) begin
      int p = (r[i] ? 4 : 0) + ((i == last && !r[i]) ? 2 : 0) + ((i > last) ? 1 : 0);
      if (p > best) begin best = p; w = i; end
    end
    return w;
  endfunction

  task automatic model(input logic [N-1:0] r, input logic d);
    if (m_busy) begin
      if (d) m_busy = 1'b0;
    end else begin
      int w = pick(r, m_last);
      if (r[w] && w == m_gnt) begin m_busy = 1'b1; m_last = w; end
      else m_gnt = w;
    end
  endtask

  task automatic compare(input string tag);
    logic [N-1:0] eg = N'(1) << m_gnt;
    n_chk++;
    if (gnt !== eg || busy !== m_busy) begin
      n_bad++;
      $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b", tag, gnt, busy, eg, m_busy);
    end
  endtask

  // called at a falling edge; returns at the next one
  task automatic step(input logic [N-1:0] r, input logic d, input string tag);
    req = r; done = d;
    model(r, d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");
    step('0, 1'b1, "R9 done while idle");
    step('0, 1'b0, "R6 rest on last");
    step(5'b01100, 1'b0, "R4 tie goes to lower index");
    step(5'b01100, 1'b0, "R3 start after grant move");
    step(5'b01000, 1'b0, "R5 hold");
    step(5'b01000, 1'b0, "R5 hold");
    step(5'b00100, 1'b1, "R5 release");
    step(5'b10000, 1'b0, "R3 move to port 4");
    step(5'b00000, 1'b0, "R8 dropped request");
    step(5'b00000, 1'b0, "R6 parked");
    step(5'b00100, 1'b0, "R7 parked start");
    step(5'b00000, 1'b1, "R5 release");
    step(5'b01011, 1'b0, "R3 above-last wins");
    step(5'b01011, 1'b0, "R3 start");
    step(5'b00000, 1'b1, "R9 done ends txn");
    step(5'b00000, 1'b1, "R9 done while idle");
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] r = N'($urandom) & N'($urandom);
      logic d = ($urandom % 4) == 0;
      string tag = m_busy ? "R5 random busy" : (r == '0 ? "R6 random idle" : "R3 random arb");
      step(r, d, tag);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule